// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Software Refill

This block translates 40-bit virtual addresses into 36-bit physical addresses for 16 KB pages. It holds 512 translations arranged as 256 sets of two ways. A lookup request carries a virtual address and a read/write flag. One cycle after the request is accepted, a registered response reports one of three outcomes: a translated physical address, a miss, or a protection trap.

The block never fetches a translation by itself. A miss tells software to install the entry through a dedicated install port. The hardware picks the way to fill on every install. Each entry carries four pieces of state:
- an access-rights field, which gates reads and writes;
- a dirty flag, which a permitted write sets;
- a referenced flag, which every permitted hit sets;
- a valid flag.

Software can sample usage by clearing all referenced flags at once. It can read the per-entry flags back through a status port. A flush pulse invalidates the whole table in one cycle.

Lookups use a valid/ready handshake on both sides. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle (`rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and no new request is taken. Install, flush, clear and status pins are plain strobes and reads.

Top module: `tlb_xlate`

## Requirements
- R1: The virtual address splits into a set index (bits 21:14), a tag (bits 39:22) and a page offset (bits 13:0). On a permitted hit, `rsp_paddr` equals the entry's 22-bit physical page number followed by the unchanged 14-bit offset.
- R2: A request accepted on a clock edge produces `rsp_valid` after that edge. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and every response output holds its value.
- R3: A lookup that matches no valid entry in its set returns `rsp_miss` with `rsp_paddr` zero, and it changes no valid, dirty or referenced flag.
- R4: An install writes into a set as follows. The lowest-numbered invalid way is filled first. If no way is invalid, the lowest-numbered way whose referenced flag is clear is filled. Otherwise way 0 is filled.
- R5: A permitted hit sets the referenced flag of the matching entry. A `ref_clear` pulse clears every referenced flag. When a clear and a permitted hit fall in the same cycle, the hit entry ends with its flag set and all others end clear.
- R6: A permitted write hit sets the dirty flag of the matching entry. An install loads the dirty flag from `ins_dirty`.
- R7: Rights encoding is 00 = no access, 01 = read only, 10 = read/write, 11 = read/write/execute. A write to a read-only entry, or any access to a no-access entry, returns `rsp_prot` with `rsp_paddr` zero and leaves the referenced and dirty flags unchanged.
- R8: A `flush` pulse, or reset, clears every valid flag in one cycle. An install in the same cycle as a flush is discarded.
- R9: If both ways of the selected set hold the looked-up tag, the response uses way 0's translation and rights, and `rsp_multi` is high.
- R10: With `rsp_valid` high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_prot` is high.
- R11: An installed entry starts with its referenced flag clear. A lookup in the same cycle as an install sees the table as it was before the install.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_vaddr | input | 40 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response register holds a result |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 36 | Physical address (zero unless `rsp_hit`) |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched (miss trap) |
| rsp_prot | output | 1 | Rights forbid the access (protection trap) |
| rsp_multi | output | 1 | Both ways matched; way 0 was used |
| ins_valid | input | 1 | Install strobe |
| ins_vpn | input | 26 | Virtual page number of the new entry |
| ins_ppn | input | 22 | Physical page number of the new entry |
| ins_rights | input | 2 | Access rights of the new entry |
| ins_dirty | input | 1 | Initial dirty flag of the new entry |
| flush | input | 1 | Invalidate all entries |
| ref_clear | input | 1 | Clear all referenced flags |
| st_set | input | 8 | Status read: set index |
| st_way | input | 1 | Status read: way |
| st_valid | output | 1 | Valid flag of the addressed entry |
| st_dirty | output | 1 | Dirty flag of the addressed entry |
| st_ref | output | 1 | Referenced flag of the addressed entry |

## Verification
Several updates can land on the same flag in the same clock edge:
- a `ref_clear` pulse and a permitted hit, on the referenced flags;
- an install and a lookup, on the same set;
- a flush and an install.

The bench raises each pair in one cycle, driving both on the same falling edge. For the clear-and-hit case it first sets the referenced flag in both ways of a set. It then clears while hitting one way, and judges through the status port that only the hit entry keeps its flag. For the other pairs it checks two things. The lookup result must reflect the pre-install table. After the flush, the entry the discarded install targeted must read as invalid.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    RIGHTS_NONE = 2'b00,
    RIGHTS_RO   = 2'b01,
    RIGHTS_RW   = 2'b10,
    RIGHTS_RWX  = 2'b11
  } rights_e;

  // True when an entry with rights r allows the access (write when wr=1)
  function automatic logic access_ok(input logic [1:0] r, input logic wr);
    case (rights_e'(r))
      RIGHTS_NONE: access_ok = 1'b0;
      RIGHTS_RO:   access_ok = !wr;
      default:     access_ok = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int SETS  = 256,
  parameter int WAYS  = 2,
  parameter int TAG_W = 18,
  parameter int PPN_W = 22,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          ref_clear,
  // lookup read
  input  logic [IDX_W-1:0]              lk_set,
  output logic [WAYS-1:0]               lk_valid,
  output logic [WAYS-1:0][TAG_W-1:0]    lk_tag,
  output logic [WAYS-1:0][PPN_W-1:0]    lk_ppn,
  output logic [WAYS-1:0][1:0]          lk_rights,
  // flag update from a permitted hit
  input  logic                          upd_en,
  input  logic [IDX_W-1:0]              upd_set,
  input  logic [WAY_W-1:0]              upd_way,
  input  logic                          upd_write,
  // install
  input  logic                          ins_en,
  input  logic [IDX_W-1:0]              ins_set,
  input  logic [WAY_W-1:0]              ins_way,
  input  logic [TAG_W-1:0]              ins_tag,
  input  logic [PPN_W-1:0]              ins_ppn,
  input  logic [1:0]                    ins_rights,
  input  logic                          ins_dirty,
  output logic [WAYS-1:0]               vs_valid,
  output logic [WAYS-1:0]               vs_ref,
  // status read
  input  logic [IDX_W-1:0]              rd_set,
  input  logic [WAY_W-1:0]              rd_way,
  output logic                          rd_valid,
  output logic                          rd_dirty,
  output logic                          rd_ref
);

  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [SETS-1:0][WAYS-1:0] ref_q;
  logic [SETS-1:0][WAYS-1:0] dirty_q;
  logic [WAYS-1:0][TAG_W-1:0] tag_q    [SETS];
  logic [WAYS-1:0][PPN_W-1:0] ppn_q    [SETS];
  logic [WAYS-1:0][1:0]       rights_q [SETS];

  logic ins_go;
  assign ins_go = ins_en && !flush;

  // Flag state: flush and reset act on every entry in one edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      if (flush)
        valid_q <= '0;
      else if (ins_en)
        valid_q[ins_set][ins_way] <= 1'b1;

      // later assignments take precedence: clear, then hit, then install
      if (ref_clear)
        ref_q <= '0;
      if (upd_en)
        ref_q[upd_set][upd_way] <= 1'b1;
      if (ins_go)
        ref_q[ins_set][ins_way] <= 1'b0;

      if (upd_en && upd_write)
        dirty_q[upd_set][upd_way] <= 1'b1;
      if (ins_go)
        dirty_q[ins_set][ins_way] <= ins_dirty;
    end
  end

  // Payload storage, no reset needed: guarded by valid
  always_ff @(posedge clk) begin
    if (ins_go) begin
      tag_q[ins_set][ins_way]    <= ins_tag;
      ppn_q[ins_set][ins_way]    <= ins_ppn;
      rights_q[ins_set][ins_way] <= ins_rights;
    end
  end

  assign lk_valid  = valid_q[lk_set];
  assign lk_tag    = tag_q[lk_set];
  assign lk_ppn    = ppn_q[lk_set];
  assign lk_rights = rights_q[lk_set];

  assign vs_valid  = valid_q[ins_set];
  assign vs_ref    = ref_q[ins_set];

  assign rd_valid  = valid_q[rd_set][rd_way];
  assign rd_dirty  = dirty_q[rd_set][rd_way];
  assign rd_ref    = ref_q[rd_set][rd_way];

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  p_hit_sets_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !(ins_go && ins_set == upd_set && ins_way == upd_way))
      |=> ref_q[$past(upd_set)][$past(upd_way)]);

  p_write_sets_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_write && !(ins_go && ins_set == upd_set && ins_way == upd_way))
      |=> dirty_q[$past(upd_set)][$past(upd_way)]);

  p_install_fresh_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ins_go |=> (valid_q[$past(ins_set)][$past(ins_way)] &&
                !ref_q[$past(ins_set)][$past(ins_way)]));

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 18,
  parameter int PPN_W = 22,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [TAG_W-1:0]             tag,
  input  logic [WAYS-1:0]              lk_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]   lk_tag,
  input  logic [WAYS-1:0][PPN_W-1:0]   lk_ppn,
  input  logic [WAYS-1:0][1:0]         lk_rights,
  output logic                         any_hit,
  output logic                         multi,
  output logic [WAY_W-1:0]             sel_way,
  output logic [PPN_W-1:0]             sel_ppn,
  output logic [1:0]                   sel_rights
);

  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = lk_valid[w] && (lk_tag[w] == tag);
  end

  // lowest matching way wins
  always_comb begin
    logic found;
    found   = 1'b0;
    sel_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w] && !found) begin
        found   = 1'b1;
        sel_way = WAY_W'(w);
      end
    end
  end

  assign any_hit    = |hit_vec;
  assign multi      = ($countones(hit_vec) > 1);
  assign sel_ppn    = lk_ppn[sel_way];
  assign sel_rights = lk_rights[sel_way];

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS  = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  set_valid,
  input  logic [WAYS-1:0]  set_ref,
  output logic [WAY_W-1:0] way
);

  always_comb begin
    logic got_free;
    logic got_cold;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] cold_way;
    got_free = 1'b0;
    got_cold = 1'b0;
    free_way = '0;
    cold_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!set_valid[w] && !got_free) begin
        got_free = 1'b1;
        free_way = WAY_W'(w);
      end
      if (!set_ref[w] && !got_cold) begin
        got_cold = 1'b1;
        cold_way = WAY_W'(w);
      end
    end
    if (got_free)      way = free_way;
    else if (got_cold) way = cold_way;
    else               way = '0;
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W       = 40,
  parameter int PA_W       = 36,
  parameter int PAGE_BYTES = 16384,
  parameter int SETS       = 256,
  parameter int WAYS       = 2,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_prot,
  output logic             rsp_multi,
  input  logic             ins_valid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [1:0]       ins_rights,
  input  logic             ins_dirty,
  input  logic             flush,
  input  logic             ref_clear,
  input  logic [IDX_W-1:0] st_set,
  input  logic [WAY_W-1:0] st_way,
  output logic             st_valid,
  output logic             st_dirty,
  output logic             st_ref
);
  import tlb_pkg::*;

  logic                       accept;
  logic [IDX_W-1:0]           lk_set;
  logic [TAG_W-1:0]           lk_tagin;
  logic [WAYS-1:0]            lk_valid;
  logic [WAYS-1:0][TAG_W-1:0] lk_tag;
  logic [WAYS-1:0][PPN_W-1:0] lk_ppn;
  logic [WAYS-1:0][1:0]       lk_rights;
  logic                       any_hit;
  logic                       multi;
  logic [WAY_W-1:0]           sel_way;
  logic [PPN_W-1:0]           sel_ppn;
  logic [1:0]                 sel_rights;
  logic                       permit;
  logic                       upd_en;
  logic [IDX_W-1:0]           ins_set;
  logic [TAG_W-1:0]           ins_tag;
  logic [WAYS-1:0]            vic_valid;
  logic [WAYS-1:0]            vic_ref;
  logic [WAY_W-1:0]           vic_way;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign lk_set    = req_vaddr[OFF_W +: IDX_W];
  assign lk_tagin  = req_vaddr[VA_W-1 -: TAG_W];
  assign ins_set   = ins_vpn[IDX_W-1:0];
  assign ins_tag   = ins_vpn[VPN_W-1 -: TAG_W];

  tlb_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .ref_clear  (ref_clear),
    .lk_set     (lk_set),
    .lk_valid   (lk_valid),
    .lk_tag     (lk_tag),
    .lk_ppn     (lk_ppn),
    .lk_rights  (lk_rights),
    .upd_en     (upd_en),
    .upd_set    (lk_set),
    .upd_way    (sel_way),
    .upd_write  (req_write),
    .ins_en     (ins_valid),
    .ins_set    (ins_set),
    .ins_way    (vic_way),
    .ins_tag    (ins_tag),
    .ins_ppn    (ins_ppn),
    .ins_rights (ins_rights),
    .ins_dirty  (ins_dirty),
    .vs_valid   (vic_valid),
    .vs_ref     (vic_ref),
    .rd_set     (st_set),
    .rd_way     (st_way),
    .rd_valid   (st_valid),
    .rd_dirty   (st_dirty),
    .rd_ref     (st_ref)
  );

  tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_match (
    .tag        (lk_tagin),
    .lk_valid   (lk_valid),
    .lk_tag     (lk_tag),
    .lk_ppn     (lk_ppn),
    .lk_rights  (lk_rights),
    .any_hit    (any_hit),
    .multi      (multi),
    .sel_way    (sel_way),
    .sel_ppn    (sel_ppn),
    .sel_rights (sel_rights)
  );

  tlb_victim #(.WAYS(WAYS)) u_victim (
    .set_valid (vic_valid),
    .set_ref   (vic_ref),
    .way       (vic_way)
  );

  assign permit = access_ok(sel_rights, req_write);
  assign upd_en = accept && any_hit && permit;

  // Response register: one stage, held under back-pressure
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_multi <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= any_hit && permit;
      rsp_miss  <= !any_hit;
      rsp_prot  <= any_hit && !permit;
      rsp_multi <= multi;
      rsp_paddr <= (any_hit && permit) ? {sel_ppn, req_vaddr[OFF_W-1:0]} : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_prot}) == 1));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
      $stable({rsp_hit, rsp_miss, rsp_prot, rsp_multi})));

  p_multi_not_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> (rsp_valid && !rsp_miss));

  p_trap_no_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));

  p_victim_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !(&vic_valid)) |-> !vic_valid[vic_way]);

endmodule

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [39:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [35:0] rsp_paddr;
  logic        rsp_hit, rsp_miss, rsp_prot, rsp_multi;
  logic        ins_valid = 1'b0;
  logic [25:0] ins_vpn = '0;
  logic [21:0] ins_ppn = '0;
  logic [1:0]  ins_rights = '0;
  logic        ins_dirty = 1'b0;
  logic        flush = 1'b0;
  logic        ref_clear = 1'b0;
  logic [7:0]  st_set = '0;
  logic        st_way = 1'b0;
  logic        st_valid, st_dirty, st_ref;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tlb_xlate i_tlb_xlate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_prot(rsp_prot), .rsp_multi(rsp_multi),
    .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
    .ins_rights(ins_rights), .ins_dirty(ins_dirty),
    .flush(flush), .ref_clear(ref_clear),
    .st_set(st_set), .st_way(st_way),
    .st_valid(st_valid), .st_dirty(st_dirty), .st_ref(st_ref)
  );

  function automatic logic [39:0] mkva(input logic [17:0] t, input logic [7:0] s, input logic [13:0] o);
    return {t, s, o};
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic install(input logic [17:0] t, input logic [7:0] s, input logic [21:0] p,
                         input logic [1:0] r, input logic d);
    ins_valid = 1'b1; ins_vpn = {t, s}; ins_ppn = p; ins_rights = r; ins_dirty = d;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic lookup(input logic [39:0] va, input logic wr);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic exp_rsp(input string r, input logic h, input logic m, input logic pr,
                         input logic mu, input logic [35:0] pa);
    chk({r, " rsp_valid"}, rsp_valid, 1'b1);
    chk({r, " hit/miss/prot/multi"}, {rsp_hit, rsp_miss, rsp_prot, rsp_multi}, {h, m, pr, mu});
    chk({r, " paddr"}, rsp_paddr, pa);
  endtask

  task automatic st_chk(input string r, input logic [7:0] s, input logic w,
                        input logic ev, input logic ed, input logic er);
    st_set = s; st_way = w;
    #1;
    chk({r, " valid/dirty/ref"}, {st_valid, st_dirty, st_ref}, {ev, ed, er});
    @(negedge clk);
  endtask

  task automatic pulse_ref_clear();
    ref_clear = 1'b1;
    @(negedge clk);
    ref_clear = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 reset rsp_valid", rsp_valid, 1'b0);
    chk("R2 reset req_ready", req_ready, 1'b1);
    st_chk("R8 reset entry", 8'h05, 1'b0, 0, 0, 0);
    st_chk("R8 reset entry", 8'hFF, 1'b1, 0, 0, 0);
  endtask

  task automatic t_translate();
    install(18'h2A5A5, 8'h05, 22'h3F00F, 2'b10, 1'b0);
    st_chk("R11 fresh entry", 8'h05, 1'b0, 1, 0, 0);
    lookup(mkva(18'h2A5A5, 8'h05, 14'h1234), 1'b0);
    exp_rsp("R1 read hit", 1, 0, 0, 0, {22'h3F00F, 14'h1234});
    st_chk("R5 ref after hit", 8'h05, 1'b0, 1, 0, 1);
    lookup(mkva(18'h2A5A5, 8'h05, 14'h3FFF), 1'b1);
    exp_rsp("R1 write hit", 1, 0, 0, 0, {22'h3F00F, 14'h3FFF});
    st_chk("R6 dirty after write", 8'h05, 1'b0, 1, 1, 1);
  endtask

  task automatic t_miss();
    lookup(mkva(18'h00111, 8'h05, 14'h0001), 1'b1);
    exp_rsp("R3 miss", 0, 1, 0, 0, 36'h0);
    st_chk("R3 way0 untouched", 8'h05, 1'b0, 1, 1, 1);
    st_chk("R3 way1 untouched", 8'h05, 1'b1, 0, 0, 0);
  endtask

  task automatic t_backpressure();
    rsp_ready = 1'b0;
    lookup(mkva(18'h2A5A5, 8'h05, 14'h0042), 1'b0);
    exp_rsp("R2 first rsp", 1, 0, 0, 0, {22'h3F00F, 14'h0042});
    req_valid = 1'b1; req_vaddr = mkva(18'h00777, 8'h05, 14'h0); req_write = 1'b0;
    #1;
    chk("R2 req_ready low when stalled", req_ready, 1'b0);
    @(negedge clk);
    exp_rsp("R2 rsp held", 1, 0, 0, 0, {22'h3F00F, 14'h0042});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    exp_rsp("R2 second rsp after drain", 0, 1, 0, 0, 36'h0);
    @(negedge clk);
    chk("R2 rsp drained", rsp_valid, 1'b0);
  endtask

  task automatic t_victim();
    install(18'h00001, 8'h10, 22'h00001, 2'b10, 1'b0);
    st_chk("R4 first into way0", 8'h10, 1'b0, 1, 0, 0);
    install(18'h00002, 8'h10, 22'h00002, 2'b10, 1'b0);
    st_chk("R4 second into free way1", 8'h10, 1'b1, 1, 0, 0);
    lookup(mkva(18'h00002, 8'h10, 14'h0), 1'b0);
    install(18'h00003, 8'h10, 22'h00003, 2'b10, 1'b0);
    lookup(mkva(18'h00001, 8'h10, 14'h0), 1'b0);
    exp_rsp("R4 cold way0 replaced", 0, 1, 0, 0, 36'h0);
    lookup(mkva(18'h00003, 8'h10, 14'h5), 1'b0);
    exp_rsp("R4 new entry hit", 1, 0, 0, 0, {22'h00003, 14'h5});
    install(18'h00004, 8'h10, 22'h00004, 2'b10, 1'b0);
    lookup(mkva(18'h00003, 8'h10, 14'h0), 1'b0);
    exp_rsp("R4 all hot picks way0", 0, 1, 0, 0, 36'h0);
    lookup(mkva(18'h00002, 8'h10, 14'h6), 1'b0);
    exp_rsp("R4 way1 kept", 1, 0, 0, 0, {22'h00002, 14'h6});
    pulse_ref_clear();
    lookup(mkva(18'h00004, 8'h10, 14'h0), 1'b0);
    install(18'h00005, 8'h10, 22'h00005, 2'b10, 1'b0);
    lookup(mkva(18'h00002, 8'h10, 14'h0), 1'b0);
    exp_rsp("R4 cold way1 replaced", 0, 1, 0, 0, 36'h0);
    lookup(mkva(18'h00004, 8'h10, 14'h7), 1'b0);
    exp_rsp("R4 hot way0 kept", 1, 0, 0, 0, {22'h00004, 14'h7});
  endtask

  task automatic t_rights();
    install(18'h00007, 8'h20, 22'h00070, 2'b01, 1'b0);
    lookup(mkva(18'h00007, 8'h20, 14'h9), 1'b0);
    exp_rsp("R7 read-only read", 1, 0, 0, 0, {22'h00070, 14'h9});
    pulse_ref_clear();
    lookup(mkva(18'h00007, 8'h20, 14'h9), 1'b1);
    exp_rsp("R7 read-only write traps", 0, 0, 1, 0, 36'h0);
    st_chk("R7 no ref/dirty on trap", 8'h20, 1'b0, 1, 0, 0);
    install(18'h00008, 8'h20, 22'h00080, 2'b00, 1'b0);
    lookup(mkva(18'h00008, 8'h20, 14'h1), 1'b0);
    exp_rsp("R7 no-access read traps", 0, 0, 1, 0, 36'h0);
    st_chk("R7 no ref on trap", 8'h20, 1'b1, 1, 0, 0);
    install(18'h00009, 8'h21, 22'h00090, 2'b11, 1'b1);
    st_chk("R6 install loads dirty", 8'h21, 1'b0, 1, 1, 0);
    lookup(mkva(18'h00009, 8'h21, 14'h2), 1'b1);
    exp_rsp("R7 rwx write allowed", 1, 0, 0, 0, {22'h00090, 14'h2});
  endtask

  task automatic t_collide();
    install(18'h0000A, 8'h30, 22'h000A0, 2'b10, 1'b0);
    install(18'h0000B, 8'h30, 22'h000B0, 2'b10, 1'b0);
    lookup(mkva(18'h0000A, 8'h30, 14'h0), 1'b0);
    lookup(mkva(18'h0000B, 8'h30, 14'h0), 1'b0);
    ref_clear = 1'b1;
    lookup(mkva(18'h0000A, 8'h30, 14'h0), 1'b0);
    ref_clear = 1'b0;
    st_chk("R5 hit wins over clear", 8'h30, 1'b0, 1, 0, 1);
    st_chk("R5 clear reaches others", 8'h30, 1'b1, 1, 0, 0);
    ins_valid = 1'b1; ins_vpn = {18'h0000C, 8'h31}; ins_ppn = 22'h000C0;
    ins_rights = 2'b10; ins_dirty = 1'b0;
    lookup(mkva(18'h0000C, 8'h31, 14'h3), 1'b0);
    ins_valid = 1'b0;
    exp_rsp("R11 lookup sees pre-install table", 0, 1, 0, 0, 36'h0);
    lookup(mkva(18'h0000C, 8'h31, 14'h3), 1'b0);
    exp_rsp("R11 entry present afterwards", 1, 0, 0, 0, {22'h000C0, 14'h3});
    flush = 1'b1;
    install(18'h0000D, 8'h32, 22'h000D0, 2'b10, 1'b0);
    flush = 1'b0;
    st_chk("R8 install dropped under flush", 8'h32, 1'b0, 0, 0, 0);
    st_chk("R8 flush clears others", 8'h30, 1'b0, 0, 0, 1);
    lookup(mkva(18'h0000A, 8'h30, 14'h0), 1'b0);
    exp_rsp("R8 miss after flush", 0, 1, 0, 0, 36'h0);
  endtask

  task automatic t_multi();
    install(18'h0000E, 8'h40, 22'h00111, 2'b10, 1'b0);
    install(18'h0000E, 8'h40, 22'h00222, 2'b01, 1'b0);
    lookup(mkva(18'h0000E, 8'h40, 14'h4), 1'b1);
    exp_rsp("R9 duplicate tag uses way0", 1, 0, 0, 1, {22'h00111, 14'h4});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_translate();
    t_miss();
    t_backpressure();
    t_victim();
    t_rights();
    t_collide();
    t_multi();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule